// File: doc/BRIEF.md
# Colour LCD Controller Register and Interrupt Block

This block is the memory-mapped control front end of a colour LCD controller. A host reaches it over a simple 32-bit register bus whose byte address covers a 4 KB window. Writes are registered on the clock edge and reads return data combinationally. The block holds four panel timing words, the upper and lower panel frame base addresses, a control word and a 32-bit interrupt mask. It decodes the active line width and panel height from packed timing fields and drives the control fields as ports for the pixel pipeline.

Frame events set two raw status bits: next-base-update (bit 2) and vertical-compare (bit 3). A frame event comes from the `frame_tick` input, and, when `FRAME_DIV` is nonzero, also from an internal cycle divider. Either source counts only while the display is active. The interrupt line is a level, and software clears status with a write-one-to-clear register. A layout strap exchanges the offsets of the control and mask registers. A second strap selects which identification byte set appears at the top of the window.

Top module: `lcdc_regs`

## Requirements
- R1: Word indices 0–3 are timing words 0–3, index 4 is the upper base and index 5 is the lower base. Each reads back the full 32 bits last written. Indices 11 and 12 are read-only and return the upper and lower base. The bases also appear on `upper_base` and `lower_base`.
- R2: With `swap_layout` low, index 6 is the mask and index 7 is control. With it high, index 6 is control and index 7 is the mask, for both reads and writes.
- R3: `pix_per_line` equals ((timing0 & 0xFC) + 4) * 4, and `lines_per_panel` equals (timing1 & 0x3FF) + 1.
- R4: `active` is high only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R5: `bpp_code` is control bits [3:1], `bgr_order` is bit 8, `be_byte` is bit 9 and `be_pixel` is bit 10.
- R6: Index 8 reads the raw status. Index 9 reads raw status AND mask. `irq` is high exactly when the masked status is nonzero.
- R7: A write to index 10 clears every raw status bit where the written data has a 1. Index 10 reads as zero.
- R8: A frame event while `active` is high sets raw status bits 2 and 3. A `frame_tick` while inactive has no effect. A frame event wins over a clear written in the same cycle.
- R9: Byte offsets 0xFE0–0xFFC return one identification byte per word in bits [7:0]. With `alt_id` low the bytes are 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. With `alt_id` high the first and third bytes become 0x11 and 0x24.
- R10: Reset clears every register and deasserts `irq`. Reads of other indices return zero, and writes to them change nothing.
- R11: With `FRAME_DIV` = N > 0, a frame event occurs N cycles after the display becomes active and then every N active cycles. The divider count returns to zero whenever the display is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| swap_layout | input | 1 | Exchanges control and mask offsets |
| alt_id | input | 1 | Selects the alternate identification bytes |
| frame_tick | input | 1 | External frame event pulse |
| irq | output | 1 | Level interrupt |
| active | output | 1 | Enable and power both set |
| bpp_code | output | 3 | Bits-per-pixel code |
| bgr_order | output | 1 | BGR colour order |
| be_byte | output | 1 | Big-endian byte order |
| be_pixel | output | 1 | Big-endian pixel order |
| upper_base | output | 32 | Upper panel base address |
| lower_base | output | 32 | Lower panel base address |
| pix_per_line | output | 11 | Decoded pixels per line |
| lines_per_panel | output | 11 | Decoded lines per panel |

## Verification
The properties assume that `bus_wr` is a clean single-cycle strobe with a stable address and data. They also assume that `frame_tick` and the straps change only between clock edges. The bench drives every input on the falling edge and holds the straps steady across any write it depends on. A strap changes only while the bus is idle. The clear-versus-event property applies only when no frame event occurs in the same cycle. The bench exercises that collision on purpose in a separate step.

// File: rtl/lcdc_regs.sv
module lcdc_regs #(
  parameter int FRAME_DIV = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        swap_layout,
  input  logic        alt_id,
  input  logic        frame_tick,
  output logic        irq,
  output logic        active,
  output logic [2:0]  bpp_code,
  output logic        bgr_order,
  output logic        be_byte,
  output logic        be_pixel,
  output logic [31:0] upper_base,
  output logic [31:0] lower_base,
  output logic [10:0] pix_per_line,
  output logic [10:0] lines_per_panel
);
  localparam int CW = (FRAME_DIV > 1) ? $clog2(FRAME_DIV) : 1;

  logic [31:0] tim_q [4];
  logic [31:0] up_q, lo_q, ctl_q, msk_q;
  logic [1:0]  raw_q;
  logic [9:0]  idx;
  logic        ctl_sel, msk_sel, tick_set, div_hit;
  logic [31:0] raw_w, mis_w;

  assign idx     = bus_addr[11:2];
  assign ctl_sel = swap_layout ? (idx == 10'd6) : (idx == 10'd7);
  assign msk_sel = swap_layout ? (idx == 10'd7) : (idx == 10'd6);

  assign active    = ctl_q[0] & ctl_q[11];
  assign bpp_code  = ctl_q[3:1];
  assign bgr_order = ctl_q[8];
  assign be_byte   = ctl_q[9];
  assign be_pixel  = ctl_q[10];
  assign upper_base = up_q;
  assign lower_base = lo_q;
  assign pix_per_line    = ({3'b0, tim_q[0][7:2]} + 11'd1) << 2 << 2;
  assign lines_per_panel = {1'b0, tim_q[1][9:0]} + 11'd1;

  assign raw_w = {28'b0, raw_q, 2'b00};
  assign mis_w = raw_w & msk_q;
  assign irq   = |mis_w;

  generate
    if (FRAME_DIV > 0) begin : g_div
      logic [CW-1:0] cnt_q;
      assign div_hit = (cnt_q == CW'(FRAME_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !active || div_hit) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_ext
      assign div_hit = 1'b0;
    end
  endgenerate

  assign tick_set = active & (frame_tick | div_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) tim_q[i] <= '0;
      up_q  <= '0;
      lo_q  <= '0;
      ctl_q <= '0;
      msk_q <= '0;
      raw_q <= '0;
    end else begin
      if (bus_wr) begin
        if (idx < 10'd4)  tim_q[idx[1:0]] <= bus_wdata;
        if (idx == 10'd4) up_q <= bus_wdata;
        if (idx == 10'd5) lo_q <= bus_wdata;
        if (ctl_sel)      ctl_q <= bus_wdata;
        if (msk_sel)      msk_q <= bus_wdata;
      end
      if (tick_set)
        raw_q <= 2'b11;
      else if (bus_wr && idx == 10'd10)
        raw_q <= raw_q & ~bus_wdata[3:2];
    end
  end

  function automatic logic [7:0] id_byte(input logic [2:0] n, input logic alt);
    case (n)
      3'd0:    id_byte = alt ? 8'h11 : 8'h10;
      3'd1:    id_byte = 8'h11;
      3'd2:    id_byte = alt ? 8'h24 : 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[11:5] == 7'h7F) begin
      bus_rdata = {24'b0, id_byte(bus_addr[4:2], alt_id)};
    end else begin
      case (idx)
        10'd0, 10'd1, 10'd2, 10'd3: bus_rdata = tim_q[idx[1:0]];
        10'd4, 10'd11: bus_rdata = up_q;
        10'd5, 10'd12: bus_rdata = lo_q;
        10'd6:  bus_rdata = swap_layout ? ctl_q : msk_q;
        10'd7:  bus_rdata = swap_layout ? msk_q : ctl_q;
        10'd8:  bus_rdata = raw_w;
        10'd9:  bus_rdata = mis_w;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module lcdc_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr,
  input logic [9:0]  idx,
  input logic [31:0] wdata,
  input logic        tick_set,
  input logic [1:0]  raw,
  input logic [31:0] mask,
  input logic        active,
  input logic        irq
);
  p_clear_bit2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 10'd10 && wdata[2] && !tick_set) |=> !raw[0]);
  p_clear_bit3_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 10'd10 && wdata[3] && !tick_set) |=> !raw[1]);
  p_event_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_set |=> (raw == 2'b11));
  p_no_event_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !tick_set);
  p_irq_needs_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask[2] || mask[3]));
  p_full_clear_drops_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 10'd10 && wdata == 32'hFFFF_FFFF && !tick_set) |=> !irq);
endmodule

bind lcdc_regs lcdc_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr(bus_wr), .idx(idx), .wdata(bus_wdata),
  .tick_set(tick_set), .raw(raw_q), .mask(msk_q), .active(active), .irq(irq)
);

// File: tb/lcdc_regs_tb.sv
module lcdc_regs_tb;
  logic clk = 0, rst_n = 0, bus_wr = 0, swap_layout = 0, alt_id = 0, frame_tick = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, rdata, rdata2;
  logic irq, active, bgr_order, be_byte, be_pixel;
  logic irq2, active2, bgr2, beb2, bep2;
  logic [2:0] bpp_code, bpp2;
  logic [31:0] upper_base, lower_base, ub2, lb2;
  logic [10:0] pix_per_line, lines_per_panel, ppl2, lpp2;
  int n_chk = 0, n_bad = 0;
  logic [31:0] v;

  always #10 clk = ~clk;

  lcdc_regs u_dut (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata(rdata),
    .swap_layout, .alt_id, .frame_tick, .irq, .active, .bpp_code, .bgr_order,
    .be_byte, .be_pixel, .upper_base, .lower_base, .pix_per_line, .lines_per_panel);

  lcdc_regs #(.FRAME_DIV(5)) u_div (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata(rdata2), .swap_layout, .alt_id, .frame_tick(1'b0), .irq(irq2),
    .active(active2), .bpp_code(bpp2), .bgr_order(bgr2), .be_byte(beb2), .be_pixel(bep2),
    .upper_base(ub2), .lower_base(lb2), .pix_per_line(ppl2), .lines_per_panel(lpp2));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input int i, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = 12'(i * 4); bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input int i, output logic [31:0] d);
    bus_addr = 12'(i * 4);
    #1 d = rdata;
  endtask

  task automatic rchk(input string tag, input int i, input logic [31:0] exp);
    logic [31:0] d;
    rd(i, d);
    chk(tag, d, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); frame_tick = 1;
    @(negedge clk); frame_tick = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    for (int i = 0; i < 13; i++) rchk("R10 reset reg", i, 0);
    chk("R10 reset irq", irq, 0);
    chk("R4 reset active", active, 0);

    // R1 readback and mirrors
    for (int i = 0; i < 6; i++) wr(i, 32'hA5C3_0000 + 32'(i * 32'h1111));
    for (int i = 0; i < 6; i++) rchk("R1 readback", i, 32'hA5C3_0000 + 32'(i * 32'h1111));
    rchk("R1 upper current", 11, 32'hA5C3_4444);
    rchk("R1 lower current", 12, 32'hA5C3_5555);
    chk("R1 upper port", upper_base, 32'hA5C3_4444);
    chk("R1 lower port", lower_base, 32'hA5C3_5555);

    // R3 width sweep over all field values
    for (int w = 0; w < 64; w++) begin
      wr(0, 32'hFFFF_FF03 | 32'(w << 2));
      chk("R3 width", 32'(pix_per_line), 32'((w * 4 + 4) * 4));
    end
    for (int h = 0; h < 1024; h += 31) begin
      wr(1, 32'hFFFF_FC00 | 32'(h));
      chk("R3 height", 32'(lines_per_panel), 32'(h + 1));
    end
    wr(1, 32'h0000_03FF);
    chk("R3 height max", 32'(lines_per_panel), 32'd1024);

    // R4 enable/power combinations
    wr(7, 32'h0000_0001); chk("R4 enable only", active, 0);
    wr(7, 32'h0000_0800); chk("R4 power only", active, 0);
    wr(7, 32'h0000_0801); chk("R4 both", active, 1);
    wr(7, 32'h0000_0000); chk("R4 none", active, 0);

    // R5 control fields
    wr(7, 32'h0000_070A);
    chk("R5 bpp", bpp_code, 5); chk("R5 bgr", bgr_order, 1);
    chk("R5 bebyte", be_byte, 1); chk("R5 bepix", be_pixel, 1);
    wr(7, 32'h0000_0104);
    chk("R5 bpp2", bpp_code, 2); chk("R5 bgr2", bgr_order, 1);
    chk("R5 bebyte2", be_byte, 0); chk("R5 bepix2", be_pixel, 0);

    // R2 layout swap
    wr(6, 32'h1234_5678);
    wr(7, 32'h8765_4320);
    rchk("R2 idx6 mask", 6, 32'h1234_5678);
    rchk("R2 idx7 ctl", 7, 32'h8765_4320);
    swap_layout = 1;
    rchk("R2 swapped idx6 ctl", 6, 32'h8765_4320);
    rchk("R2 swapped idx7 mask", 7, 32'h1234_5678);
    wr(6, 32'h0000_0801);
    chk("R2 swapped write to ctl", active, 1);
    rchk("R2 mask untouched", 7, 32'h1234_5678);
    wr(7, 32'h0);
    swap_layout = 0;
    rchk("R2 mask via idx6", 6, 0);
    rchk("R2 ctl via idx7", 7, 32'h0000_0801);

    // R8 / R6 / R7 interrupt path
    wr(10, 32'hFFFF_FFFF);
    pulse_tick();
    rchk("R8 raw after tick", 8, 32'h0000_000C);
    rchk("R6 masked none", 9, 0);
    chk("R6 irq masked off", irq, 0);
    wr(6, 32'h0000_0004);
    rchk("R6 masked bit2", 9, 32'h4);
    chk("R6 irq on", irq, 1);
    wr(10, 32'h0000_0004);
    rchk("R7 clear bit2", 8, 32'h8);
    chk("R6 irq off after clear", irq, 0);
    rchk("R7 clear reads zero", 10, 0);
    wr(6, 32'h0000_0008);
    chk("R6 irq bit3", irq, 1);
    wr(10, 32'h0000_0008);
    rchk("R7 clear bit3", 8, 0);
    chk("R6 irq off", irq, 0);

    wr(7, 32'h0000_0001);
    pulse_tick();
    rchk("R8 inactive tick ignored", 8, 0);
    chk("R8 irq stays low", irq, 0);

    wr(7, 32'h0000_0801);
    @(negedge clk);
    frame_tick = 1; bus_wr = 1; bus_addr = 12'd40; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    frame_tick = 0; bus_wr = 0;
    rchk("R8 event wins over clear", 8, 32'hC);
    wr(10, 32'hFFFF_FFFF);
    wr(6, 0);
    wr(7, 0);

    // R9 identification bytes for both straps
    for (int a = 0; a < 2; a++) begin
      alt_id = a[0];
      for (int k = 0; k < 8; k++) begin
        logic [7:0] e;
        case (k)
          0: e = a ? 8'h11 : 8'h10;
          1: e = 8'h11;
          2: e = a ? 8'h24 : 8'h04;
          3: e = 8'h00;
          4: e = 8'h0D;
          5: e = 8'hF0;
          6: e = 8'h05;
          default: e = 8'hB1;
        endcase
        rchk("R9 id byte", 1016 + k, {24'b0, e});
      end
    end
    alt_id = 0;

    // R10 undefined offsets
    for (int i = 13; i < 1016; i++) rchk("R10 undefined read", i, 0);
    wr(13, 32'hFFFF_FFFF); wr(200, 32'hFFFF_FFFF); wr(1015, 32'hFFFF_FFFF);
    wr(1016, 32'hFFFF_FFFF);
    rchk("R10 timing2 intact", 2, 32'hA5C3_2222);
    rchk("R10 upper intact", 4, 32'hA5C3_4444);
    rchk("R10 ctl intact", 7, 0);
    rchk("R10 mask intact", 6, 0);
    rchk("R10 raw intact", 8, 0);
    rchk("R10 id intact", 1016, 32'h10);

    // R11 internal divider
    wr(10, 32'hFFFF_FFFF);
    wr(7, 32'h0000_0801);
    bus_addr = 12'd32;
    repeat (4) @(negedge clk);
    #1 chk("R11 before period", rdata2, 0);
    @(negedge clk);
    #1 chk("R11 at period", rdata2, 32'hC);
    wr(10, 32'hC);
    wr(7, 0);
    repeat (3) @(negedge clk);
    wr(7, 32'h0000_0801);
    bus_addr = 12'd32;
    repeat (4) @(negedge clk);
    #1 chk("R11 count restarted", rdata2, 0);
    @(negedge clk);
    #1 chk("R11 period after restart", rdata2, 32'hC);

    // R10 reset clears everything again
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    rchk("R10 reset ctl", 7, 0);
    rchk("R10 reset upper", 4, 0);
    chk("R10 reset irq2", irq, 0);
    finish_run();
  end
endmodule